// File: doc/BRIEF.md
# Attribute Fetch Address Override Sequencer

This block sits beside a tile-based video fetch engine. It watches the engine's active-low read strobe and its 14-bit video address. When a read finishes that was a tile-index fetch, the block keeps two coordinate bits of that fetch and arms itself. It then treats the very next read as the attribute fetch, whatever address that read carries, and pulls selected attribute address lines low for the length of that read.

The lines are modelled as open-drain lanes: one enable per lane, with a data value that is always 0. A native attribute fetch has address bits 9..6 all high, so pulling a line low acts as a logical AND on the address. This folds the attribute read into a compact shared area in single-screen mode. A region-select input gives a second half-screen its own area by also pulling line 8.

Everything runs on a sampling clock that is much faster than the read strobe. Reset is asserted asynchronously and released in step with the clock.

Top module: `vfo_attr_override`

## Requirements
- R1: After reset, all three drive enables `drv_oe` are 0 and no read is armed. `drv_lvl` is 0 at all times.
- R2: A read is a tile-index fetch when address bit 13 is 1, bit 12 is 0 and bits 9..6 are not all 1. When such a read completes (rd_n returns high), fine X (address bit 0) and fine Y (address bit 5) are latched and the override is armed.
- R3: While the block is armed, the next read is overridden whatever its address.
- R4: During an overridden read, `drv_oe[0]` (address line 6) is 1 exactly when the latched fine X is 0. `drv_oe[1]` (address line 7) is 1 exactly when the latched fine Y is 0.
- R5: During an overridden read, `drv_oe[2]` (address line 8) is 1 exactly when `region_sel` was 1 at the first clock edge of that read.
- R6: The arm is cleared when the overridden read completes. A read that is not a tile-index fetch and is not overridden leaves the block unarmed, so no later read is overridden until a new tile-index fetch completes.
- R7: `drv_oe` is all 0 whenever rd_n is 1. Within a read, the enables take their value at the first rising clock edge at which rd_n is sampled low, and they keep that value until rd_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd_n | input | 1 | Active-low read strobe of the fetch engine |
| vaddr | input | 14 | Video address bus |
| region_sel | input | 1 | Selects the second half-screen attribute area |
| drv_oe | output | 3 | Pull-low enables for address lines 6, 7, 8 (bit 0..2) |
| drv_lvl | output | 3 | Value driven on an enabled lane, always 0 |

## Verification
The assertions check on every cycle that the enables stay quiet while the strobe is idle and that an enable only appears while the block is armed. They also check that each coordinate lane agrees with the latched coordinate bit, and that the arm drops once an armed read completes. Only the bench scenarios can show the complete sequence: which addresses count as tile-index fetches, that the override follows cadence and not address, the region lane, and that the enables hold their value through a multi-cycle read.

// File: rtl/vfo_pkg.sv
package vfo_pkg;
  localparam int unsigned VADDR_W   = 14;
  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned LANE_FX   = 0;  // pulls address line 6
  localparam int unsigned LANE_FY   = 1;  // pulls address line 7
  localparam int unsigned LANE_REG  = 2;  // pulls address line 8

  typedef struct packed {
    logic fy;
    logic fx;
  } fine_t;
endpackage

// File: rtl/vfo_strobe.sv
module vfo_strobe #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_n,
  output logic rst_sync_n,
  output logic rd_start,
  output logic rd_end
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rd_q;
  logic                   rd_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  always_comb rd_d = rd_n;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_q <= 1'b1;
    else             rd_q <= rd_d;
  end

  assign rd_start = ~rd_n & rd_q;
  assign rd_end   = rd_n & ~rd_q;
endmodule

// File: rtl/vfo_fetch_track.sv
module vfo_fetch_track
  import vfo_pkg::*;
#(
  parameter int unsigned AW     = VADDR_W,
  parameter int unsigned FX_BIT = 0,
  parameter int unsigned FY_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_sync_n,
  input  logic          rd_n,
  input  logic          rd_end,
  input  logic [AW-1:0] vaddr,
  output logic          armed,
  output fine_t         fine
);
  logic [AW-1:0] addr_q, addr_d;
  logic          hold_en;
  logic          is_tile;
  logic          arm_d;
  fine_t         fine_d;

  assign hold_en = ~rd_n;

  always_comb begin
    addr_d = addr_q;
    if (hold_en) addr_d = vaddr;
  end

  always_comb begin
    is_tile = addr_q[13] & ~addr_q[12] & ~(&addr_q[9:6]);
  end

  always_comb begin
    arm_d  = armed;
    fine_d = fine;
    if (rd_end) begin
      if (armed) begin
        arm_d = 1'b0;
      end else if (is_tile) begin
        arm_d   = 1'b1;
        fine_d.fx = addr_q[FX_BIT];
        fine_d.fy = addr_q[FY_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      armed  <= 1'b0;
      fine   <= '0;
    end else begin
      addr_q <= addr_d;
      armed  <= arm_d;
      fine   <= fine_d;
    end
  end
endmodule

// File: rtl/vfo_lane_drive.sv
module vfo_lane_drive
  import vfo_pkg::*;
#(
  parameter int unsigned LANES = NUM_LANES
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             rd_n,
  input  logic             rd_start,
  input  logic             armed,
  input  fine_t            fine,
  input  logic             region_sel,
  output logic [LANES-1:0] drv_oe,
  output logic [LANES-1:0] drv_lvl
);
  logic [LANES-1:0] req;
  logic [LANES-1:0] drv_q, drv_d;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == LANE_FX) begin : g_fx
      assign req[i] = ~fine.fx;
    end else if (i == LANE_FY) begin : g_fy
      assign req[i] = ~fine.fy;
    end else begin : g_reg
      assign req[i] = region_sel;
    end
    assign drv_lvl[i] = 1'b0;
    assign drv_oe[i]  = drv_q[i] & ~rd_n;
  end

  always_comb begin
    drv_d = drv_q;
    if (rd_n)          drv_d = '0;
    else if (rd_start) drv_d = armed ? req : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) drv_q <= '0;
    else             drv_q <= drv_d;
  end
endmodule

// File: rtl/vfo_attr_override.sv
module vfo_attr_override
  import vfo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_n,
  input  logic [VADDR_W-1:0]   vaddr,
  input  logic                 region_sel,
  output logic [NUM_LANES-1:0] drv_oe,
  output logic [NUM_LANES-1:0] drv_lvl
);
  logic  rst_sync_n;
  logic  rd_start, rd_end;
  logic  armed;
  fine_t fine;

  vfo_strobe #(.SYNC_STAGES(2)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_n       (rd_n),
    .rst_sync_n (rst_sync_n),
    .rd_start   (rd_start),
    .rd_end     (rd_end)
  );

  vfo_fetch_track #(.AW(VADDR_W), .FX_BIT(0), .FY_BIT(5)) u_track (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .rd_n       (rd_n),
    .rd_end     (rd_end),
    .vaddr      (vaddr),
    .armed      (armed),
    .fine       (fine)
  );

  vfo_lane_drive #(.LANES(NUM_LANES)) u_drive (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .rd_n       (rd_n),
    .rd_start   (rd_start),
    .armed      (armed),
    .fine       (fine),
    .region_sel (region_sel),
    .drv_oe     (drv_oe),
    .drv_lvl    (drv_lvl)
  );
endmodule

// File: rtl/vfo_attr_override_chk.sv
module vfo_attr_override_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic       rd_n,
  input logic       armed,
  input logic       fine_x,
  input logic       fine_y,
  input logic [2:0] drv_oe
);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_n |-> drv_oe == 3'b000);

  a_r3_drive_needs_arm: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (drv_oe != 3'b000) |-> armed);

  a_r4_finex_lane: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drv_oe[0] |-> !fine_x);

  a_r4_finey_lane: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drv_oe[1] |-> !fine_y);

  a_r6_arm_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($rose(rd_n) && armed) |=> !armed);
endmodule

bind vfo_attr_override vfo_attr_override_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_n       (rd_n),
  .armed      (armed),
  .fine_x     (fine.fx),
  .fine_y     (fine.fy),
  .drv_oe     (drv_oe)
);

// File: tb/vfo_attr_override_bench.sv
`timescale 1ns/1ps
module vfo_attr_override_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_n;
  logic [13:0] vaddr;
  logic        region_sel;
  logic [2:0]  drv_oe;
  logic [2:0]  drv_lvl;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  vfo_attr_override u_vfo_attr_override (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .vaddr(vaddr),
    .region_sel(region_sel), .drv_oe(drv_oe), .drv_lvl(drv_lvl)
  );

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One read: two clock edges with rd_n low, then release.
  task automatic do_read(input logic [13:0] a, input logic r,
                         output logic [2:0] oe_a, output logic [2:0] oe_b,
                         output logic [2:0] oe_idle);
    rd_n = 1'b0; vaddr = a; region_sel = r;
    @(negedge clk); oe_a = drv_oe;
    @(negedge clk); oe_b = drv_oe;
    rd_n = 1'b1; region_sel = 1'b0;
    #0.5 oe_idle = drv_oe;
    @(negedge clk);
  endtask

  task automatic read_expect(input string req, input logic [13:0] a, input logic r,
                             input logic [2:0] exp);
    logic [2:0] x, y, z;
    do_read(a, r, x, y, z);
    chk(req, x, exp);
    chk({req, " (held, R7)"}, y, exp);
    chk("R7 idle quiet", z, 3'b000);
    chk("R1 level low", drv_lvl, 3'b000);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rd_n = 1'b1; vaddr = '0; region_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset enables", drv_oe, 3'b000);
    chk("R1 reset level", drv_lvl, 3'b000);
    read_expect("R1 unarmed after reset", 14'h23C0, 1'b1, 3'b000);
  endtask

  task automatic t_fine_patterns();
    read_expect("R2 tile fetch no drive", 14'h2000, 1'b0, 3'b000);
    read_expect("R4 fx0 fy0", 14'h23C0, 1'b0, 3'b011);
    read_expect("R2 tile fetch", 14'h2001, 1'b0, 3'b000);
    read_expect("R4 fx1 fy0", 14'h23C0, 1'b0, 3'b010);
    read_expect("R2 tile fetch", 14'h2020, 1'b0, 3'b000);
    read_expect("R4 fx0 fy1", 14'h23C0, 1'b0, 3'b001);
    read_expect("R2 tile fetch", 14'h2821, 1'b0, 3'b000);
    read_expect("R4 fx1 fy1", 14'h2BC0, 1'b0, 3'b000);
  endtask

  task automatic t_region();
    read_expect("R2 tile fetch", 14'h2000, 1'b1, 3'b000);
    read_expect("R5 region lane", 14'h23C0, 1'b1, 3'b111);
    read_expect("R2 tile fetch", 14'h2021, 1'b0, 3'b000);
    read_expect("R5 region only", 14'h23C0, 1'b1, 3'b100);
  endtask

  task automatic t_cadence();
    read_expect("R2 tile fetch", 14'h2000, 1'b0, 3'b000);
    read_expect("R3 any address overridden", 14'h0123, 1'b0, 3'b011);
    read_expect("R2 tile fetch", 14'h2000, 1'b0, 3'b000);
    read_expect("R3 tile-like address overridden", 14'h2021, 1'b0, 3'b011);
    read_expect("R6 no rearm from overridden read", 14'h23C0, 1'b0, 3'b000);
  endtask

  task automatic t_clear();
    read_expect("R2 tile fetch", 14'h2000, 1'b0, 3'b000);
    read_expect("R6 overridden", 14'h23C0, 1'b0, 3'b011);
    read_expect("R6 cleared after override", 14'h23C0, 1'b0, 3'b000);
    read_expect("R2 attr area not tile", 14'h23C0, 1'b0, 3'b000);
    read_expect("R6 still unarmed", 14'h23C0, 1'b0, 3'b000);
    read_expect("R2 bit12 set not tile", 14'h3000, 1'b0, 3'b000);
    read_expect("R6 unarmed after 0x3000", 14'h23C0, 1'b0, 3'b000);
    read_expect("R2 bit13 clear not tile", 14'h1000, 1'b0, 3'b000);
    read_expect("R6 unarmed after 0x1000", 14'h23C0, 1'b0, 3'b000);
  endtask

  initial begin
    t_reset();
    t_fine_patterns();
    t_region();
    t_cadence();
    t_clear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule